// File: doc/BRIEF.md
# Multi-format serial audio transmitter

This block turns stereo sample pairs into a continuous serial audio stream. It drives one primary data output and, in lockstep, a second data output that carries its own left/right pair. It also drives a left/right word clock and, when asked, a bit clock output. The bit clock is divided down from the system clock. Each word-clock half spans 32 bit periods, so one frame is 64 bit periods. A two-bit format code chooses how each sample sits inside its half: I2S, left justified, right justified with 20 data bits, or right justified with 16 data bits. Both data outputs always use the same format.

Samples arrive on a valid/ready handshake. There is one beat per frame, and it carries all four channel words. `in_ready` is a one-cycle pulse that occurs once per frame, in the system-clock cycle before the frame boundary. A source that wants to send must hold `in_valid` and its data stable until it sees `in_ready` high. That cycle is the transfer. Back-pressure is therefore fixed at the frame rate. If `in_valid` is low in the ready cycle, the block transmits an all-zero frame and does not stall. The format code is captured in the same cycle as the samples, so a code change takes effect only at the next frame.

The control pins are plain levels:
- The master enable gates the whole block.
- The second-output enable gates the second data output.
- The clock enable gates only the bit clock pin. Data and word clock keep running for receivers that recover their own serial clock.

Top module: `sat_tx`

## Requirements
- R1: Format code 00 (I2S). The word clock is low for the left half and high for the right half. The 20-bit sample is sent MSB first in bit periods 1..20 of its half. All other bit periods of the half are 0.
- R2: Format code 01 (left justified). The word clock is high for the left half and low for the right half. The 20-bit sample is sent MSB first in bit periods 0..19 of its half. All other bit periods are 0.
- R3: Format code 10 (right justified, 20 bits). The word clock is high for the left half. The 20-bit sample is sent MSB first in bit periods 12..31, so its LSB is the last bit before the next word-clock edge. Bit periods 0..11 are 0.
- R4: Format code 11 (right justified, 16 bits). The word clock is high for the left half. Sample bits 19..4 are sent MSB first in bit periods 16..31. Bit periods 0..15 are 0, and sample bits 3..0 are not sent.
- R5: One bit period is 2*HALF_PER system clocks, and one frame is 64 bit periods. The word clock and both data outputs change only at the falling edge of the bit clock.
- R6: `in_ready` is high for exactly one system clock per frame, while the bit clock is high just before the frame boundary. The samples and the format code are taken only in that cycle. A format change at any other time does not affect the frame already in progress.
- R7: If `in_valid` is low in the ready cycle, every bit of the following frame is 0 on both data outputs.
- R8: While `en` is 0, `in_ready` and `sclk_o` are 0 at once. From the next clock edge on, `ws_o`, `sd0_o` and `sd1_o` are 0 as well. When `en` is set again, transmission restarts with a new handshake.
- R9: `sd1_o` carries the pair `in_l1`/`in_r1` in the same format and the same bit timing as `sd0_o`. A bit period that starts while `en2` is 0 puts 0 on `sd1_o`.
- R10: `sclk_o` follows the bit clock only while both `sck_en` and `en` are 1, and is 0 otherwise. The word clock and the data outputs are unaffected by `sck_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Master enable for the whole transmitter |
| en2 | input | 1 | Enable for the second data output |
| sck_en | input | 1 | Enable for the bit clock pin |
| fmt_sel | input | 2 | Format code (00 I2S, 01 left, 10 right 20-bit, 11 right 16-bit) |
| in_valid | input | 1 | Sample beat is valid |
| in_ready | output | 1 | One-cycle pulse per frame; the beat transfers when valid is also high |
| in_l0 | input | SAMPLE_W | Left sample for the primary output |
| in_r0 | input | SAMPLE_W | Right sample for the primary output |
| in_l1 | input | SAMPLE_W | Left sample for the second output |
| in_r1 | input | SAMPLE_W | Right sample for the second output |
| sclk_o | output | 1 | Gated bit clock |
| ws_o | output | 1 | Word clock (left/right select) |
| sd0_o | output | 1 | Primary serial data |
| sd1_o | output | 1 | Second serial data |

## Verification
The handshake is the reference point for all timing. Bit period k of a frame appears on the outputs at the falling bit-clock edge that comes k bit periods after the transfer edge, which is 1 + 4k system clocks after the ready cycle with the default divider. The bench samples every data and word-clock bit on the falling clock edge that follows that register update, and it checks the bit clock at the midpoint of each bit period, two clocks later. The handshake spacing is compared against 256 clocks. When the enable is dropped, `in_ready` and `sclk_o` are checked on the next sample and the registered outputs one edge later.

// File: rtl/sat_pkg.sv
package sat_pkg;

  typedef enum logic [1:0] {
    FMT_I2S  = 2'b00,
    FMT_LJ   = 2'b01,
    FMT_RJW  = 2'b10,
    FMT_RJ16 = 2'b11
  } sat_fmt_e;

  // number of data bits carried by the narrow right-justified mode
  localparam int NARROW_W = 16;

  // word clock level for a given half: I2S marks left with low,
  // the justified modes mark left with high
  function automatic logic ws_level(sat_fmt_e f, logic right_half);
    return (f == FMT_I2S) ? right_half : ~right_half;
  endfunction

endpackage

// File: rtl/sat_bclk_div.sv
module sat_bclk_div #(
  parameter int HALF_PER = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic bclk,
  output logic fall_tick
);
  localparam int CW = (HALF_PER > 1) ? $clog2(HALF_PER) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(HALF_PER - 1);

  logic [CW-1:0] cnt;
  logic          at_last;

  assign at_last   = run && (cnt == CNT_LAST);
  assign fall_tick = at_last && bclk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      bclk <= 1'b0;
    end else if (!run) begin
      cnt  <= '0;
      bclk <= 1'b0;
    end else if (at_last) begin
      cnt  <= '0;
      bclk <= ~bclk;
    end else begin
      cnt  <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/sat_frame_seq.sv
module sat_frame_seq
  import sat_pkg::*;
#(
  parameter int SW        = 20,
  parameter int SLOT_BITS = 32,
  parameter int NCH       = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              run,
  input  logic                              fall_tick,
  input  logic [1:0]                        fmt_in,
  input  logic                              in_valid,
  input  logic [NCH-1:0][SW-1:0]            in_smp,
  output logic                              in_ready,
  output logic [$clog2(2*SLOT_BITS)-1:0]    nxt_pos,
  output sat_fmt_e                          nxt_fmt,
  output logic [NCH-1:0][SW-1:0]            nxt_smp
);
  localparam int FB = 2 * SLOT_BITS;
  localparam int PW = $clog2(FB);
  localparam logic [PW-1:0] POS_LAST = PW'(FB - 1);

  logic [PW-1:0]         pos;
  sat_fmt_e              fmt_q;
  logic [NCH-1:0][SW-1:0] smp_q;
  logic                  wrap;

  // the frame boundary is the falling bit-clock edge that leaves the last bit
  assign wrap     = fall_tick && (pos == POS_LAST);
  assign in_ready = wrap;

  always_comb begin
    nxt_pos = (pos == POS_LAST) ? '0 : pos + 1'b1;
    if (wrap) begin
      nxt_fmt = sat_fmt_e'(fmt_in);
      nxt_smp = in_valid ? in_smp : '0;
    end else begin
      nxt_fmt = fmt_q;
      nxt_smp = smp_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos   <= POS_LAST;
      fmt_q <= FMT_I2S;
      smp_q <= '0;
    end else if (!run) begin
      pos   <= POS_LAST;
      fmt_q <= FMT_I2S;
      smp_q <= '0;
    end else if (fall_tick) begin
      pos   <= nxt_pos;
      fmt_q <= nxt_fmt;
      smp_q <= nxt_smp;
    end
  end
endmodule

// File: rtl/sat_lane_fmt.sv
module sat_lane_fmt
  import sat_pkg::*;
#(
  parameter int SW        = 20,
  parameter int SLOT_BITS = 32
) (
  input  sat_fmt_e                        fmt,
  input  logic [$clog2(2*SLOT_BITS)-1:0]  pos,
  input  logic [SW-1:0]                   left,
  input  logic [SW-1:0]                   right,
  output logic                            bit_o
);
  localparam int PW  = $clog2(2 * SLOT_BITS);
  localparam int SBW = PW - 1;

  logic [SW-1:0] word;
  logic [SW-1:0] shifted;
  int            slot_idx;
  int            off;
  int            len;
  int            rel;
  logic          in_win;

  always_comb begin
    word     = pos[SBW] ? right : left;
    slot_idx = int'(pos[SBW-1:0]);
    unique case (fmt)
      FMT_I2S: begin off = 1;                    len = SW;       end
      FMT_LJ:  begin off = 0;                    len = SW;       end
      FMT_RJW: begin off = SLOT_BITS - SW;       len = SW;       end
      default: begin off = SLOT_BITS - NARROW_W; len = NARROW_W; end
    endcase
    in_win  = (slot_idx >= off) && (slot_idx < off + len);
    rel     = in_win ? (slot_idx - off) : 0;
    shifted = word << rel;
    bit_o   = in_win && shifted[SW-1];
  end
endmodule

// File: rtl/sat_tx.sv
module sat_tx
  import sat_pkg::*;
#(
  parameter int SAMPLE_W  = 20,
  parameter int SLOT_BITS = 32,
  parameter int HALF_PER  = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                en2,
  input  logic                sck_en,
  input  logic [1:0]          fmt_sel,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SAMPLE_W-1:0] in_l0,
  input  logic [SAMPLE_W-1:0] in_r0,
  input  logic [SAMPLE_W-1:0] in_l1,
  input  logic [SAMPLE_W-1:0] in_r1,
  output logic                sclk_o,
  output logic                ws_o,
  output logic                sd0_o,
  output logic                sd1_o
);
  localparam int PW    = $clog2(2 * SLOT_BITS);
  localparam int NLANE = 2;
  localparam int NCH   = 2 * NLANE;

  logic                         bclk;
  logic                         fall_tick;
  logic [NCH-1:0][SAMPLE_W-1:0] in_pack;
  logic [PW-1:0]                nxt_pos;
  sat_fmt_e                     nxt_fmt;
  logic [NCH-1:0][SAMPLE_W-1:0] nxt_smp;
  logic [NLANE-1:0]             lane_bit;
  logic                         ws_nxt;

  assign in_pack = {in_r1, in_l1, in_r0, in_l0};

  sat_bclk_div #(.HALF_PER(HALF_PER)) u_div (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (en),
    .bclk      (bclk),
    .fall_tick (fall_tick)
  );

  sat_frame_seq #(.SW(SAMPLE_W), .SLOT_BITS(SLOT_BITS), .NCH(NCH)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (en),
    .fall_tick (fall_tick),
    .fmt_in    (fmt_sel),
    .in_valid  (in_valid),
    .in_smp    (in_pack),
    .in_ready  (in_ready),
    .nxt_pos   (nxt_pos),
    .nxt_fmt   (nxt_fmt),
    .nxt_smp   (nxt_smp)
  );

  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    sat_lane_fmt #(.SW(SAMPLE_W), .SLOT_BITS(SLOT_BITS)) u_lane (
      .fmt   (nxt_fmt),
      .pos   (nxt_pos),
      .left  (nxt_smp[2*g]),
      .right (nxt_smp[2*g+1]),
      .bit_o (lane_bit[g])
    );
  end

  assign ws_nxt = ws_level(nxt_fmt, nxt_pos[PW-1]);

  // all serial outputs move together on the falling bit-clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ws_o  <= 1'b0;
      sd0_o <= 1'b0;
      sd1_o <= 1'b0;
    end else if (!en) begin
      ws_o  <= 1'b0;
      sd0_o <= 1'b0;
      sd1_o <= 1'b0;
    end else if (fall_tick) begin
      ws_o  <= ws_nxt;
      sd0_o <= lane_bit[0];
      sd1_o <= lane_bit[1] && en2;
    end
  end

  assign sclk_o = bclk && sck_en && en;
endmodule

// File: rtl/sat_tx_chk.sv
module sat_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic en2,
  input logic sck_en,
  input logic in_ready,
  input logic sclk_o,
  input logic ws_o,
  input logic sd0_o,
  input logic sd1_o,
  input logic bclk
);
  // R5: data and word clock move only together with a falling bit clock
  a_r5_sd0_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && !$stable(sd0_o)) |-> $fell(bclk));
  a_r5_ws_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en) && !$stable(ws_o)) |-> $fell(bclk));

  // R6: ready is a single-cycle pulse taken while the bit clock is high
  a_r6_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |=> !in_ready);
  a_r6_ready_phase: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> bclk);

  // R8: disabled block is silent
  a_r8_idle_comb: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!in_ready && !sclk_o));
  a_r8_idle_regs: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && $past(!en)) |-> (!sd0_o && !sd1_o && !ws_o));

  // R9: a bit period started with the second enable low carries zero
  a_r9_sd1_gated: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(bclk) && $past(!en2)) |-> !sd1_o);

  // R10: no clock on the pin while its enable is low
  a_r10_sclk_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !sck_en |-> !sclk_o);
endmodule

bind sat_tx sat_tx_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .en       (en),
  .en2      (en2),
  .sck_en   (sck_en),
  .in_ready (in_ready),
  .sclk_o   (sclk_o),
  .ws_o     (ws_o),
  .sd0_o    (sd0_o),
  .sd1_o    (sd1_o),
  .bclk     (bclk)
);

// File: tb/test_sat_tx.sv
module test_sat_tx;
  localparam int SW = 20;
  localparam int HP = 2;
  localparam int BP = 2 * HP;
  localparam int FB = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, en2 = 1'b0, sck_en = 1'b0;
  logic [1:0] fmt = 2'b00;
  logic in_valid = 1'b0;
  logic [SW-1:0] l0 = '0, r0 = '0, l1 = '0, r1 = '0;
  logic in_ready, sclk_o, ws_o, sd0_o, sd1_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  sat_tx #(.SAMPLE_W(SW), .SLOT_BITS(32), .HALF_PER(HP)) i_sat_tx (
    .clk(clk), .rst_n(rst_n), .en(en), .en2(en2), .sck_en(sck_en),
    .fmt_sel(fmt), .in_valid(in_valid), .in_ready(in_ready),
    .in_l0(l0), .in_r0(r0), .in_l1(l1), .in_r1(r1),
    .sclk_o(sclk_o), .ws_o(ws_o), .sd0_o(sd0_o), .sd1_o(sd1_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic string fmt_req(logic [1:0] f);
    case (f)
      2'b00:   return "R1";
      2'b01:   return "R2";
      2'b10:   return "R3";
      default: return "R4";
    endcase
  endfunction

  // expected bit in period k of a frame (R1..R4)
  function automatic logic exp_bit(logic [1:0] f, int k, logic [SW-1:0] l, logic [SW-1:0] r);
    int s = k % 32;
    logic [SW-1:0] w = (k >= 32) ? r : l;
    case (f)
      2'b00:   return (s >= 1 && s <= 20) ? w[20-s] : 1'b0;
      2'b01:   return (s <= 19) ? w[19-s] : 1'b0;
      2'b10:   return (s >= 12) ? w[31-s] : 1'b0;
      default: return (s >= 16) ? w[35-s] : 1'b0;
    endcase
  endfunction

  function automatic logic exp_ws(logic [1:0] f, int k);
    if (f == 2'b00) return (k >= 32);
    return (k < 32);
  endfunction

  // deserialize one half of a captured frame into a 20-bit word
  function automatic logic [SW-1:0] recover(logic [1:0] f, logic [63:0] c, int h);
    int first, n;
    logic [SW-1:0] w = '0;
    case (f)
      2'b00:   begin first = 1;  n = 20; end
      2'b01:   begin first = 0;  n = 20; end
      2'b10:   begin first = 12; n = 20; end
      default: begin first = 16; n = 16; end
    endcase
    for (int i = 0; i < n; i++) w = {w[SW-2:0], c[h*32+first+i]};
    if (n == 16) w = w << 4;
    return w;
  endfunction

  function automatic logic [SW-1:0] exp_word(logic [1:0] f, logic v, logic [SW-1:0] s);
    if (!v) return '0;
    if (f == 2'b11) return {s[19:4], 4'b0000};
    return s;
  endfunction

  task automatic set_stim(input int f);
    case (f)
      0: begin fmt = 2'b00; in_valid = 1; l0 = 20'h80001; r0 = 20'h7FFFE; l1 = 20'h12345; r1 = 20'hEDCBA; en2 = 1; sck_en = 1; end
      1: begin fmt = 2'b01; in_valid = 1; l0 = 20'hFFFFF; r0 = 20'h00001; l1 = 20'h80000; r1 = 20'h5A5A5; en2 = 1; sck_en = 1; end
      2: begin fmt = 2'b10; in_valid = 1; l0 = 20'h80001; r0 = 20'hC0003; l1 = 20'hFFFFF; r1 = 20'h00010; en2 = 1; sck_en = 1; end
      3: begin fmt = 2'b11; in_valid = 1; l0 = 20'hABCDF; r0 = 20'h8000F; l1 = 20'h0001F; r1 = 20'hFFFFF; en2 = 1; sck_en = 1; end
      4: begin fmt = 2'b00; in_valid = 0; l0 = 20'hFFFFF; r0 = 20'hFFFFF; l1 = 20'hFFFFF; r1 = 20'hFFFFF; en2 = 1; sck_en = 1; end
      5: begin fmt = 2'b01; in_valid = 1; l0 = 20'h13579; r0 = 20'h2468A; l1 = 20'hFFFFF; r1 = 20'hFFFFF; en2 = 0; sck_en = 1; end
      6: begin fmt = 2'b10; in_valid = 1; l0 = 20'h0F0F0; r0 = 20'hF0F0F; l1 = 20'h33333; r1 = 20'hCCCCC; en2 = 1; sck_en = 0; end
      7: begin fmt = 2'b11; in_valid = 1; l0 = 20'hFFFFF; r0 = 20'hFFFFF; l1 = 20'hFFFFF; r1 = 20'hFFFFF; en2 = 1; sck_en = 1; end
      default: begin
        fmt      = 2'($urandom % 4);
        in_valid = ($urandom % 6) != 0;
        l0 = 20'($urandom); r0 = 20'($urandom);
        l1 = 20'($urandom); r1 = 20'($urandom);
        en2    = ($urandom % 4) != 0;
        sck_en = 1'($urandom % 2);
      end
    endcase
  endtask

  task automatic run_frames(input int f0, input int nf);
    int last = -1;
    logic [1:0] e_fmt;
    logic e_valid, en2_old, sclk_ok;
    logic [SW-1:0] e_l0, e_r0, e_l1, e_r1;
    logic [63:0] cap0, cap1, capw, x0, x1, xw;
    string rq;
    for (int f = f0; f < f0 + nf; f++) begin
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      if (last >= 0) chk((cyc - last) == FB * BP, "R5", "frame spacing", 64'(cyc - last), 64'(FB * BP));
      last = cyc;
      e_fmt = fmt; e_valid = in_valid; en2_old = en2;
      e_l0 = l0; e_r0 = r0; e_l1 = l1; e_r1 = r1;
      @(negedge clk);
      chk(!in_ready, "R6", "ready pulse width", 64'(in_ready), 64'd0);
      cap0[0] = sd0_o; cap1[0] = sd1_o; capw[0] = ws_o;
      sclk_ok = !sclk_o;
      // next frame's stimulus, including a new format, arrives mid-frame (R6)
      set_stim(f + 1);
      for (int k = 1; k < FB; k++) begin
        repeat (HP) @(negedge clk);
        sclk_ok = sclk_ok && (sclk_o == sck_en);
        repeat (HP) @(negedge clk);
        cap0[k] = sd0_o; cap1[k] = sd1_o; capw[k] = ws_o;
        sclk_ok = sclk_ok && !sclk_o;
      end
      for (int k = 0; k < FB; k++) begin
        x0[k] = e_valid && exp_bit(e_fmt, k, e_l0, e_r0);
        x1[k] = e_valid && exp_bit(e_fmt, k, e_l1, e_r1) && ((k == 0) ? en2_old : en2);
        xw[k] = exp_ws(e_fmt, k);
      end
      rq = e_valid ? fmt_req(e_fmt) : "R7";
      chk(recover(e_fmt, cap0, 0) == exp_word(e_fmt, e_valid, e_l0), rq, "left word sd0",
          64'(recover(e_fmt, cap0, 0)), 64'(exp_word(e_fmt, e_valid, e_l0)));
      chk(recover(e_fmt, cap0, 1) == exp_word(e_fmt, e_valid, e_r0), rq, "right word sd0",
          64'(recover(e_fmt, cap0, 1)), 64'(exp_word(e_fmt, e_valid, e_r0)));
      chk(cap0 == x0, rq, "sd0 bit stream incl. padding", cap0, x0);
      chk(capw == xw, fmt_req(e_fmt), "word clock pattern", capw, xw);
      chk(cap1 == x1, "R9", "sd1 bit stream", cap1, x1);
      chk(sclk_ok, "R10", "gated bit clock", 64'(sclk_ok), 64'd1);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_bad++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd4202));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state, block disabled (R8)
    chk({in_ready, sclk_o, ws_o, sd0_o, sd1_o} == 5'b0, "R8", "reset outputs",
        64'({in_ready, sclk_o, ws_o, sd0_o, sd1_o}), 64'd0);
    set_stim(0);
    begin
      logic quiet = 1'b1;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        quiet = quiet && !(in_ready || sclk_o || ws_o || sd0_o || sd1_o);
      end
      chk(quiet, "R8", "silent while disabled with enables set", 64'(quiet), 64'd1);
    end
    en = 1'b1;
    run_frames(0, 36);
    // drop the master enable in the middle of a frame (R8)
    repeat (40) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk(!in_ready && !sclk_o, "R8", "ready and clock off at once", 64'({in_ready, sclk_o}), 64'd0);
    begin
      logic quiet = 1'b1;
      for (int i = 0; i < 30; i++) begin
        @(negedge clk);
        quiet = quiet && !(in_ready || sclk_o || ws_o || sd0_o || sd1_o);
      end
      chk(quiet, "R8", "all outputs low after disable", 64'(quiet), 64'd1);
    end
    set_stim(1);
    en = 1'b1;
    run_frames(1, 4);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule